// File: doc/BRIEF.md
# Page Swap Integrity Sequencer

This block orders the work needed to exchange a page between the physical memory and swap while one on-chip tree root keeps covering both. Each page that is sent to swap leaves its page root in a directory region of physical memory. That region is a leaf range of the same integrity tree, so the directory entries are protected like any other memory.

One command names three things: the page coming in, the page going out and the physical frame they trade. The sequencer then issues five sub-operations, one at a time, on a request/response port. The tree datapath, hash engine and DMA engine sit behind that port.

The five steps run in a fixed order:

1. A verified read of the incoming page's directory entry.
2. A directory write that parks the outgoing page's root.
3. An invalidation of the trusted cached nodes under the frame.
4. An install of the incoming root at the frame's place in the tree, with the update of the path above it.
5. The frame data load.

The counter block travels with the page, so a swap never calls for re-encryption. No step asks for it.

If any step reports a verification failure, the exchange stops at once and an error flag is raised.

Top module: `swap_page_seq`

## Requirements
- R1: While idle, `cmd_ready` is 1. A command accepted on a clock edge makes `req_valid` 1 after that edge, with `op_kind`=1 (directory read), `op_addr` = DIR_BASE + incoming page, and `op_page` = incoming page.
- R2: The request kinds appear strictly in the order 1 (directory read), 2 (directory write), 3 (invalidate), 4 (install), 5 (frame load). Each kind is issued only after the response to the previous one.
- R3: The directory write has `op_addr` = DIR_BASE + outgoing page and `op_page` = outgoing page. The invalidate has `op_addr` = frame (zero-extended) and `op_page` = outgoing page.
- R4: The install has `op_addr` = frame and carries in `op_root` the root returned with the successful directory read response. All other kinds drive `op_root` to 0.
- R5: The frame load has `op_addr` = frame and `op_page` = incoming page.
- R6: While `req_valid` is 1 and `req_ready` is 0, the request and its fields stay unchanged. After the request/ready handshake, `req_valid` is 0 until the response arrives.
- R7: A response with `rsp_fail`=1 to any step makes `busy` 0 and `err` 1 on the next cycle. No further request is issued.
- R8: `busy` is 1 from the cycle after command accept until the cycle after the final response or an abort. A successful fifth response gives a one-cycle `done` pulse with `err`=0.
- R9: While busy, `cmd_ready` is 0 and a presented command has no effect on the requests issued.
- R10: A response that arrives while no request is awaiting one is ignored: `busy`, `err` and the pending request are unchanged.
- R11: Accepting a new command clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Exchange command present |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_in_page | input | PAGE_W | Logical id of the page brought in |
| cmd_out_page | input | PAGE_W | Logical id of the page sent to swap |
| cmd_frame | input | FRAME_W | Physical frame being exchanged |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Last exchange aborted on a verification failure |
| req_valid | output | 1 | Sub-operation request valid |
| req_ready | input | 1 | Sub-operation request taken |
| op_kind | output | 3 | 1 dir read, 2 dir write, 3 invalidate, 4 install, 5 frame load |
| op_addr | output | ADDR_W | Directory entry address or frame number |
| op_page | output | PAGE_W | Page id the sub-operation concerns |
| op_root | output | ROOT_W | Page root for install, else 0 |
| rsp_valid | input | 1 | Sub-operation response |
| rsp_fail | input | 1 | Response reports a verification failure |
| rsp_root | input | ROOT_W | Root returned by the directory read |

## Verification
The assertions take for granted that the responder answers once per accepted request. They also assume `rsp_fail` carries meaning only together with `rsp_valid`. Under those terms, each issued kind must follow the last accepted one by exactly one, and an abort must silence the request port.

The stimulus keeps to that: it gives one response per handshake after a variable latency, and raises `rsp_fail` only on the step chosen for abort. The one exception is a deliberate stray response while a request is still pending, which checks that such a response is discarded.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_DIR_RD  = 3'd1,
        OP_DIR_WR  = 3'd2,
        OP_INVAL   = 3'd3,
        OP_INSTALL = 3'd4,
        OP_LOAD    = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam int unsigned NUM_STEPS = 5;

endpackage

// File: rtl/sws_cmd_store.sv
module sws_cmd_store #(
    parameter int unsigned PAGE_W  = 20,
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned ROOT_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_cmd,
    input  logic [PAGE_W-1:0]  in_page_i,
    input  logic [PAGE_W-1:0]  out_page_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               load_root,
    input  logic [ROOT_W-1:0]  root_i,
    output logic [PAGE_W-1:0]  in_page_o,
    output logic [PAGE_W-1:0]  out_page_o,
    output logic [FRAME_W-1:0] frame_o,
    output logic [ROOT_W-1:0]  root_o
);

    typedef struct packed {
        logic [PAGE_W-1:0]  in_page;
        logic [PAGE_W-1:0]  out_page;
        logic [FRAME_W-1:0] frame;
        logic [ROOT_W-1:0]  root;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_cmd) begin
            st_d.in_page  = in_page_i;
            st_d.out_page = out_page_i;
            st_d.frame    = frame_i;
            st_d.root     = '0;
        end
        if (load_root) begin
            st_d.root = root_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_page_o  = st_q.in_page;
    assign out_page_o = st_q.out_page;
    assign frame_o    = st_q.frame;
    assign root_o     = st_q.root;

endmodule

// File: rtl/sws_step_fsm.sv
module sws_step_fsm
    import sws_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid,
    input  logic     req_ready,
    input  logic     rsp_valid,
    input  logic     rsp_fail,
    output logic     cmd_fire,
    output op_kind_e step,
    output logic     req_valid,
    output logic     busy,
    output logic     in_wait,
    output logic     done,
    output logic     err,
    output logic     root_take
);

    typedef struct packed {
        phase_e   phase;
        op_kind_e step;
        logic     done;
        logic     err;
    } fsm_t;

    fsm_t s_d, s_q;
    logic rsp_ok;
    logic last_step;

    assign busy      = (s_q.phase != PH_IDLE);
    assign req_valid = (s_q.phase == PH_ISSUE);
    assign in_wait   = (s_q.phase == PH_WAIT);
    assign cmd_fire  = cmd_valid && !busy;
    assign rsp_ok    = in_wait && rsp_valid && !rsp_fail;
    assign last_step = (s_q.step == OP_LOAD);
    assign root_take = rsp_ok && (s_q.step == OP_DIR_RD);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (cmd_fire) begin
                    s_d.phase = PH_ISSUE;
                    s_d.step  = OP_DIR_RD;
                    s_d.err   = 1'b0;
                end
            end
            PH_ISSUE: begin
                if (req_ready) begin
                    s_d.phase = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_fail) begin
                        s_d.phase = PH_IDLE;
                        s_d.step  = OP_NONE;
                        s_d.err   = 1'b1;
                    end else if (last_step) begin
                        s_d.phase = PH_IDLE;
                        s_d.step  = OP_NONE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_ISSUE;
                        s_d.step  = op_kind_e'(s_q.step + 3'd1);
                    end
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
                s_d.step  = OP_NONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, step: OP_NONE, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign step = s_q.step;
    assign done = s_q.done;
    assign err  = s_q.err;

endmodule

// File: rtl/sws_req_fmt.sv
module sws_req_fmt
    import sws_pkg::*;
#(
    parameter int unsigned PAGE_W   = 20,
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned ROOT_W   = 64,
    parameter int unsigned ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] DIR_BASE = '0
) (
    input  op_kind_e           step,
    input  logic [PAGE_W-1:0]  in_page,
    input  logic [PAGE_W-1:0]  out_page,
    input  logic [FRAME_W-1:0] frame,
    input  logic [ROOT_W-1:0]  root,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [PAGE_W-1:0]  op_page,
    output logic [ROOT_W-1:0]  op_root
);

    localparam int unsigned PAD_PG = ADDR_W - PAGE_W;
    localparam int unsigned PAD_FR = ADDR_W - FRAME_W;

    logic [ADDR_W-1:0] in_entry;
    logic [ADDR_W-1:0] out_entry;
    logic [ADDR_W-1:0] frame_addr;

    assign in_entry   = DIR_BASE + {{PAD_PG{1'b0}}, in_page};
    assign out_entry  = DIR_BASE + {{PAD_PG{1'b0}}, out_page};
    assign frame_addr = {{PAD_FR{1'b0}}, frame};

    always_comb begin
        op_addr = '0;
        op_page = '0;
        op_root = '0;
        unique case (step)
            OP_DIR_RD: begin
                op_addr = in_entry;
                op_page = in_page;
            end
            OP_DIR_WR: begin
                op_addr = out_entry;
                op_page = out_page;
            end
            OP_INVAL: begin
                op_addr = frame_addr;
                op_page = out_page;
            end
            OP_INSTALL: begin
                op_addr = frame_addr;
                op_page = in_page;
                op_root = root;
            end
            OP_LOAD: begin
                op_addr = frame_addr;
                op_page = in_page;
            end
            default: begin
                op_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/swap_page_seq.sv
module swap_page_seq
    import sws_pkg::*;
#(
    parameter int unsigned PAGE_W   = 20,
    parameter int unsigned FRAME_W  = 16,
    parameter int unsigned ROOT_W   = 64,
    parameter int unsigned ADDR_W   = 40,
    parameter logic [ADDR_W-1:0] DIR_BASE = 40'hF0_0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [PAGE_W-1:0]  cmd_in_page,
    input  logic [PAGE_W-1:0]  cmd_out_page,
    input  logic [FRAME_W-1:0] cmd_frame,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [2:0]         op_kind,
    output logic [ADDR_W-1:0]  op_addr,
    output logic [PAGE_W-1:0]  op_page,
    output logic [ROOT_W-1:0]  op_root,
    input  logic               rsp_valid,
    input  logic               rsp_fail,
    input  logic [ROOT_W-1:0]  rsp_root
);

    logic               cmd_fire;
    logic               in_wait;
    logic               root_take;
    op_kind_e           step;
    logic [PAGE_W-1:0]  st_in_page;
    logic [PAGE_W-1:0]  st_out_page;
    logic [FRAME_W-1:0] st_frame;
    logic [ROOT_W-1:0]  st_root;

    sws_step_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_fail  (rsp_fail),
        .cmd_fire  (cmd_fire),
        .step      (step),
        .req_valid (req_valid),
        .busy      (busy),
        .in_wait   (in_wait),
        .done      (done),
        .err       (err),
        .root_take (root_take)
    );

    sws_cmd_store #(
        .PAGE_W  (PAGE_W),
        .FRAME_W (FRAME_W),
        .ROOT_W  (ROOT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cmd   (cmd_fire),
        .in_page_i  (cmd_in_page),
        .out_page_i (cmd_out_page),
        .frame_i    (cmd_frame),
        .load_root  (root_take),
        .root_i     (rsp_root),
        .in_page_o  (st_in_page),
        .out_page_o (st_out_page),
        .frame_o    (st_frame),
        .root_o     (st_root)
    );

    sws_req_fmt #(
        .PAGE_W   (PAGE_W),
        .FRAME_W  (FRAME_W),
        .ROOT_W   (ROOT_W),
        .ADDR_W   (ADDR_W),
        .DIR_BASE (DIR_BASE)
    ) u_fmt (
        .step     (step),
        .in_page  (st_in_page),
        .out_page (st_out_page),
        .frame    (st_frame),
        .root     (st_root),
        .op_addr  (op_addr),
        .op_page  (op_page),
        .op_root  (op_root)
    );

    assign cmd_ready = !busy;
    assign op_kind   = 3'(step);

endmodule

// File: rtl/sws_checker.sv
module sws_checker #(
    parameter int unsigned ADDR_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic              rsp_valid,
    input logic              rsp_fail,
    input logic              in_wait
);

    logic [2:0] last_kind_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_kind_q <= 3'd0;
        end else if (cmd_valid && cmd_ready) begin
            last_kind_q <= 3'd0;
        end else if (req_valid && req_ready) begin
            last_kind_q <= op_kind;
        end
    end

    AST_KIND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (op_kind == last_kind_q + 3'd1)); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(op_kind) && $stable(op_addr)); // R6

    AST_QUIET_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R6

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && rsp_valid && rsp_fail |=> err && !busy && !req_valid); // R7

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !err); // R8

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready); // R9

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R8

    AST_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !in_wait && rsp_valid |=> busy && $stable(err)); // R10

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !err && busy); // R11

endmodule

bind swap_page_seq sws_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .op_kind   (op_kind),
    .op_addr   (op_addr),
    .rsp_valid (rsp_valid),
    .rsp_fail  (rsp_fail),
    .in_wait   (in_wait)
);

// File: tb/swap_page_seq_tb.sv
module swap_page_seq_tb;

    localparam int unsigned PAGE_W  = 20;
    localparam int unsigned FRAME_W = 16;
    localparam int unsigned ROOT_W  = 64;
    localparam int unsigned ADDR_W  = 40;
    localparam logic [ADDR_W-1:0] DIR_BASE = 40'hF0_0000_0000;

    typedef struct packed {
        logic [PAGE_W-1:0]  in_page;
        logic [PAGE_W-1:0]  out_page;
        logic [FRAME_W-1:0] frame;
        logic [ROOT_W-1:0]  root;
        logic [2:0]         fail_step;
        logic [2:0]         lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{20'h00001, 20'h00002, 16'h0010, 64'h1111_2222_3333_4444, 3'd0, 3'd0},
        '{20'hABCDE, 20'h12345, 16'hFFFF, 64'hDEAD_BEEF_0BAD_F00D, 3'd0, 3'd4},
        '{20'h00100, 20'h00200, 16'h0300, 64'h0F0F_0F0F_0F0F_0F0F, 3'd1, 3'd1},
        '{20'h00777, 20'h00888, 16'h0999, 64'hAAAA_5555_AAAA_5555, 3'd3, 3'd2},
        '{20'hFFFFF, 20'h00000, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd3},
        '{20'h0C0DE, 20'h0F00D, 16'h1234, 64'h0123_4567_89AB_CDEF, 3'd5, 3'd0}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [PAGE_W-1:0]  cmd_in_page = '0;
    logic [PAGE_W-1:0]  cmd_out_page = '0;
    logic [FRAME_W-1:0] cmd_frame = '0;
    logic               busy, done, err, req_valid;
    logic               req_ready = 1'b0;
    logic [2:0]         op_kind;
    logic [ADDR_W-1:0]  op_addr;
    logic [PAGE_W-1:0]  op_page;
    logic [ROOT_W-1:0]  op_root;
    logic               rsp_valid = 1'b0;
    logic               rsp_fail = 1'b0;
    logic [ROOT_W-1:0]  rsp_root = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    swap_page_seq #(
        .PAGE_W (PAGE_W), .FRAME_W (FRAME_W), .ROOT_W (ROOT_W),
        .ADDR_W (ADDR_W), .DIR_BASE (DIR_BASE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
        .cmd_in_page (cmd_in_page), .cmd_out_page (cmd_out_page), .cmd_frame (cmd_frame),
        .busy (busy), .done (done), .err (err),
        .req_valid (req_valid), .req_ready (req_ready),
        .op_kind (op_kind), .op_addr (op_addr), .op_page (op_page), .op_root (op_root),
        .rsp_valid (rsp_valid), .rsp_fail (rsp_fail), .rsp_root (rsp_root)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_xchg(input vec_t v, input bit poke_cmd, input bit poke_rsp);
        logic [ADDR_W-1:0] exp_addr;
        logic [PAGE_W-1:0] exp_page;
        logic [ROOT_W-1:0] exp_root;
        @(negedge clk);
        cmd_valid    = 1'b1;
        cmd_in_page  = v.in_page;
        cmd_out_page = v.out_page;
        cmd_frame    = v.frame;
        chk(cmd_ready, "R1 ready when idle", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy, "R8 busy after accept", 64'(busy), 64'd1);
        chk(!err, "R11 err cleared on accept", 64'(err), 64'd0);
        for (int s = 1; s <= 5; s++) begin
            for (int w = 0; w < 40 && !req_valid; w++) @(negedge clk);
            chk(req_valid && op_kind == 3'(s), "R2 kind order", 64'(op_kind), 64'(s));
            exp_root = '0;
            case (s)
                1: begin exp_addr = DIR_BASE + ADDR_W'(v.in_page);  exp_page = v.in_page;  end
                2: begin exp_addr = DIR_BASE + ADDR_W'(v.out_page); exp_page = v.out_page; end
                3: begin exp_addr = ADDR_W'(v.frame); exp_page = v.out_page; end
                4: begin exp_addr = ADDR_W'(v.frame); exp_page = v.in_page; exp_root = v.root; end
                default: begin exp_addr = ADDR_W'(v.frame); exp_page = v.in_page; end
            endcase
            if (s == 1) chk(op_addr == exp_addr, "R1 dir read addr", 64'(op_addr), 64'(exp_addr));
            else if (s <= 3) chk(op_addr == exp_addr, "R3 addr", 64'(op_addr), 64'(exp_addr));
            else if (s == 4) chk(op_addr == exp_addr, "R4 install addr", 64'(op_addr), 64'(exp_addr));
            else chk(op_addr == exp_addr, "R5 load addr", 64'(op_addr), 64'(exp_addr));
            if (s == 5) chk(op_page == exp_page, "R5 load page", 64'(op_page), 64'(exp_page));
            else chk(op_page == exp_page, "R3 page field", 64'(op_page), 64'(exp_page));
            chk(op_root == exp_root, "R4 root field", op_root, exp_root);
            if (poke_cmd && s == 1) begin
                cmd_valid    = 1'b1;
                cmd_in_page  = ~v.in_page;
                cmd_out_page = ~v.out_page;
                cmd_frame    = ~v.frame;
                chk(!cmd_ready, "R9 not ready while busy", 64'(cmd_ready), 64'd0);
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(req_valid && op_addr == exp_addr, "R9 command ignored", 64'(op_addr), 64'(exp_addr));
            end
            if (poke_rsp && s == 2) begin
                rsp_valid = 1'b1;
                rsp_fail  = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_fail  = 1'b0;
                chk(busy && !err && req_valid && op_kind == 3'd2, "R10 stray response ignored",
                    64'({busy, err, req_valid}), 64'b101);
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk(!req_valid, "R6 quiet after handshake", 64'(req_valid), 64'd0);
            for (int d = 0; d < int'(v.lat); d++) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_fail  = (int'(v.fail_step) == s);
            rsp_root  = (s == 1) ? v.root : ~v.root;
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_fail  = 1'b0;
            if (int'(v.fail_step) == s) begin
                chk(!busy && err, "R7 abort flags", 64'({busy, err}), 64'b01);
                for (int q = 0; q < 3; q++) begin
                    @(negedge clk);
                    chk(!req_valid && !busy, "R7 no further request", 64'(req_valid), 64'd0);
                end
                return;
            end
        end
        chk(done && !busy && !err, "R8 done pulse", 64'({done, busy, err}), 64'b100);
        @(negedge clk);
        chk(!done, "R8 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !req_valid && cmd_ready && !err && !done, "R1 reset state",
            64'({busy, req_valid, cmd_ready, err, done}), 64'b00100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !busy, "R1 idle after reset", 64'(cmd_ready), 64'd1);
        for (int i = 0; i < NVEC; i++) run_xchg(VECS[i], 1'b0, 1'b0);
        run_xchg(VECS[1], 1'b1, 1'b1);
        run_xchg(VECS[2], 1'b0, 1'b0);
        run_xchg(VECS[0], 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule